// File: doc/BRIEF.md
# Per-Lane Read Leveling Aligner

This block takes read data already captured by each byte lane's own strobe and lines the lanes up so that the system sees one coherent read word per clock. On a wide memory interface the lanes can reach the controller up to almost a full period apart. Depending on the phase, that can push a lane into the next cycle. Each lane therefore gets a programmable delay path with three parts. The first is an optional half-cycle register. The second is an optional full-cycle register pair. The third is a final register that hands every lane to the shared output.

The model works at half-cycle resolution. The block is clocked at twice the system word rate, so one `clk` edge is one half-cycle step. A lane word is held for two steps. A setting `d` adds `d` steps in total: bit 1 of a lane's setting adds two steps (full cycle) and bit 0 adds one step (half cycle).

The delays are set by a startup calibration sequencer. When software pulses the request, the data source drives all-zero words and then all-one words on every lane. The sequencer records the step at which each lane first shows the zero-to-ones transition. It then gives each lane enough added delay to match the latest lane. The settings stay in registers that can be read back until a reset or a new request.

Top module: `rd_level_aligner`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is driven to zero after that edge: data, settings, busy, done and error.
- R2: A lane word sampled at edge k appears on that lane's slice of `aligned_dout` after edge k+1+d. Here d = 2*bit1 + bit0 of the lane's 2-bit field in `lane_dly`, and lane i's field is at bits [2i+1:2i].
- R3: A `cal_req` high at an edge clears `lane_dly`, `cal_done` and `cal_err` and sets `cal_busy` after that edge. `cal_done` and `cal_busy` are never high together.
- R4: During calibration a lane's arrival is the first step at which its captured word is all ones, having been all zeros at the step before. Once recorded, an arrival is not changed until the next request.
- R5: When every lane has an arrival and the largest spread is at most 3 steps, each lane's delay is set to the latest arrival minus its own arrival. `cal_done` then rises, `cal_err` stays low and `cal_busy` falls.
- R6: After a successful calibration with steady data, every lane presents the word the source launched in the same system cycle.
- R7: If any lane would need more than 3 half-cycle steps, calibration ends with `cal_done` and `cal_err` high and all settings zero.
- R8: If some lane shows no transition within `CAL_TIMEOUT` steps of the request, calibration ends with `cal_done` and `cal_err` high and all settings zero.
- R9: Outside calibration, `lane_dly` holds its value whatever appears on the lanes, including a fresh training pattern.
- R10: A request that arrives while calibration is running restarts it, and only arrivals seen after the restart are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle step clock (twice the word rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_req | input | 1 | One-step pulse that starts or restarts calibration |
| lane_din | input | NUM_LANES*LANE_W | Captured read data, lane i at bits [LANE_W*i +: LANE_W] |
| aligned_dout | output | NUM_LANES*LANE_W | Leveled read word, same lane layout |
| lane_dly | output | NUM_LANES*2 | Per-lane settings, bit 1 full cycle, bit 0 half cycle |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Settings latched by the last calibration |
| cal_err | output | 1 | Last calibration failed; settings forced to zero |

## Verification
The bench covers several skew patterns, including every lane equally late, a fully staggered set that needs all four delay values, and a reversed order. A sequencer that subtracted in the wrong direction, or swapped the full and half bits, would send lanes out from different source cycles, and the per-step alignment model would catch it. A spread of four steps and a lane stuck at zero target the two error exits. A design that clipped the delay, or hung waiting on the dead lane, would report done without error or would never finish. A restart in the middle of training, and a second training pattern sent with no request, show whether stale arrivals leak into the settings and whether the settings move when they must not.

// File: rtl/rla_pkg.sv
// Shared types and constants for the read leveling aligner.
// Assumes a delay setting is two bits: full-cycle enable over half-cycle enable.
package rla_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TRAIN = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_e;

    localparam int unsigned DLY_BITS     = 2;
    localparam int unsigned MAX_ADD_HALF = 3;
endpackage

// File: rtl/rla_lane_path.sv
// One lane's delay path: capture register, optional half-cycle register,
// optional full-cycle register pair, and the shared output register.
// Assumes clk runs at half-cycle resolution; dly[0] adds one step, dly[1] adds two.
module rla_lane_path #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] din,
    input  logic [1:0]        dly,
    output logic [LANE_W-1:0] cap,
    output logic [LANE_W-1:0] dout
);
    logic [LANE_W-1:0] cap_q;
    logic [LANE_W-1:0] half_q;
    logic [LANE_W-1:0] full_q1;
    logic [LANE_W-1:0] full_q2;
    logic [LANE_W-1:0] out_q;
    logic [LANE_W-1:0] half_sel;
    logic [LANE_W-1:0] full_sel;

    // Choose whether the half-cycle and full-cycle stages are in the path.
    always_comb begin
        half_sel = dly[0] ? half_q : cap_q;
        full_sel = dly[1] ? full_q2 : half_sel;
    end

    // Advance the lane pipeline by one half-cycle step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= '0;
            half_q  <= '0;
            full_q1 <= '0;
            full_q2 <= '0;
            out_q   <= '0;
        end else begin
            cap_q   <= din;
            half_q  <= cap_q;
            full_q1 <= half_sel;
            full_q2 <= full_q1;
            out_q   <= full_sel;
        end
    end

    assign cap  = cap_q;
    assign dout = out_q;

    AST_ZERO_DELAY_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (dly == 2'd0 && $past(dly) == 2'd0 && $past(rst_n)) |=> (dout == $past(din, 2))); // R2
endmodule

// File: rtl/rla_edge_detect.sv
// Records the step at which one lane first turns from all zeros to all ones
// during training. Assumes clr is the calibration request and has priority.
module rla_edge_detect #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [LANE_W-1:0] cap,
    input  logic [CNT_W-1:0]  step,
    output logic              seen,
    output logic [CNT_W-1:0]  arr
);
    logic             prev_zero_q;
    logic             seen_q;
    logic [CNT_W-1:0] arr_q;
    logic             hit;

    // A transition is all ones now after all zeros one step earlier.
    always_comb begin
        hit = en && !seen_q && prev_zero_q && (cap == {LANE_W{1'b1}});
    end

    // Track the previous word and latch the first arrival step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_zero_q <= 1'b0;
            seen_q      <= 1'b0;
            arr_q       <= '0;
        end else if (clr) begin
            prev_zero_q <= 1'b0;
            seen_q      <= 1'b0;
            arr_q       <= '0;
        end else begin
            prev_zero_q <= (cap == '0);
            if (hit) begin
                seen_q <= 1'b1;
                arr_q  <= step;
            end
        end
    end

    assign seen = seen_q;
    assign arr  = arr_q;

    AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !clr) |=> seen_q); // R4
    AST_ARRIVAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !clr) |=> $stable(arr_q)); // R4
endmodule

// File: rtl/rla_setting_calc.sv
// Turns recorded arrivals into per-lane delay settings: each lane is delayed
// up to the latest arrival. fit is low when any lane needs more than the max.
module rla_setting_calc #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned CNT_W     = 7
) (
    input  logic [NUM_LANES*CNT_W-1:0]            arr_flat,
    output logic [NUM_LANES*rla_pkg::DLY_BITS-1:0] enc,
    output logic                                  fit
);
    import rla_pkg::*;

    logic [CNT_W-1:0] latest;

    // Find the latest arrival, then each lane's distance to it.
    always_comb begin
        latest = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (arr_flat[i*CNT_W +: CNT_W] > latest) begin
                latest = arr_flat[i*CNT_W +: CNT_W];
            end
        end
        fit = 1'b1;
        enc = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            logic [CNT_W-1:0] gap;
            gap = latest - arr_flat[i*CNT_W +: CNT_W];
            if (gap > CNT_W'(MAX_ADD_HALF)) begin
                fit = 1'b0;
            end
            enc[i*DLY_BITS +: DLY_BITS] = gap[DLY_BITS-1:0];
        end
    end
endmodule

// File: rtl/rla_cal_seq.sv
// Calibration sequencer: runs the training window, latches settings or flags
// an error, and holds settings until reset or a new request.
// Assumes the request is a pulse; a request in any state restarts training.
module rla_cal_seq #(
    parameter int unsigned NUM_LANES   = 4,
    parameter int unsigned CAL_TIMEOUT = 64,
    parameter int unsigned CNT_W       = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cal_req,
    input  logic                                  all_seen,
    input  logic                                  fit,
    input  logic [NUM_LANES*rla_pkg::DLY_BITS-1:0] enc_in,
    output logic [CNT_W-1:0]                      step,
    output logic                                  train_on,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  err,
    output logic [NUM_LANES*rla_pkg::DLY_BITS-1:0] dly_out
);
    import rla_pkg::*;

    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(CAL_TIMEOUT - 1);

    seq_state_e                       state_q;
    logic [CNT_W-1:0]                 step_q;
    logic                             busy_q;
    logic                             done_q;
    logic                             err_q;
    logic [NUM_LANES*DLY_BITS-1:0]    dly_q;

    // Sequence the training window and latch the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            step_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            dly_q   <= '0;
        end else if (cal_req) begin
            state_q <= SEQ_TRAIN;
            step_q  <= '0;
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            dly_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_TRAIN: begin
                    step_q <= step_q + 1'b1;
                    if (all_seen) begin
                        state_q <= SEQ_DONE;
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                        err_q   <= !fit;
                        dly_q   <= fit ? enc_in : '0;
                    end else if (step_q == LAST_STEP) begin
                        state_q <= SEQ_DONE;
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        dly_q   <= '0;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    assign step     = step_q;
    assign train_on = (state_q == SEQ_TRAIN);
    assign busy     = busy_q;
    assign done     = done_q;
    assign err      = err_q;
    assign dly_out  = dly_q;

    AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |=> (busy_q && !done_q && !err_q && dly_q == '0)); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && busy_q)); // R3
    AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (done_q && dly_q == '0)); // R7
    AST_TRAIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (step_q <= LAST_STEP)); // R8
    AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_req && !busy_q) |=> $stable(dly_q)); // R9
endmodule

// File: rtl/rd_level_aligner.sv
// Per-lane read leveling aligner top. Each lane passes through its own
// programmable delay path; the calibration sequencer picks the delays from a
// zero-to-ones training burst so all lanes leave on the same step.
// Assumes clk is the half-cycle step clock and lane_din is already captured.
module rd_level_aligner #(
    parameter int unsigned NUM_LANES   = 4,
    parameter int unsigned LANE_W      = 8,
    parameter int unsigned CAL_TIMEOUT = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cal_req,
    input  logic [NUM_LANES*LANE_W-1:0]   lane_din,
    output logic [NUM_LANES*LANE_W-1:0]   aligned_dout,
    output logic [NUM_LANES*2-1:0]        lane_dly,
    output logic                          cal_busy,
    output logic                          cal_done,
    output logic                          cal_err
);
    import rla_pkg::*;

    localparam int unsigned CNT_W = $clog2(CAL_TIMEOUT + 1);

    logic [NUM_LANES*DLY_BITS-1:0] dly_set;
    logic [NUM_LANES*DLY_BITS-1:0] enc;
    logic [NUM_LANES*CNT_W-1:0]    arr_flat;
    logic [NUM_LANES-1:0]          seen_vec;
    logic [CNT_W-1:0]              step;
    logic                          train_on;
    logic                          fit;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cap;

        rla_lane_path #(.LANE_W(LANE_W)) u_path (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (lane_din[g*LANE_W +: LANE_W]),
            .dly   (dly_set[g*DLY_BITS +: DLY_BITS]),
            .cap   (cap),
            .dout  (aligned_dout[g*LANE_W +: LANE_W])
        );

        rla_edge_detect #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cal_req),
            .en    (train_on),
            .cap   (cap),
            .step  (step),
            .seen  (seen_vec[g]),
            .arr   (arr_flat[g*CNT_W +: CNT_W])
        );
    end

    rla_setting_calc #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_calc (
        .arr_flat (arr_flat),
        .enc      (enc),
        .fit      (fit)
    );

    rla_cal_seq #(
        .NUM_LANES   (NUM_LANES),
        .CAL_TIMEOUT (CAL_TIMEOUT),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cal_req  (cal_req),
        .all_seen (&seen_vec),
        .fit      (fit),
        .enc_in   (enc),
        .step     (step),
        .train_on (train_on),
        .busy     (cal_busy),
        .done     (cal_done),
        .err      (cal_err),
        .dly_out  (dly_set)
    );

    assign lane_dly = dly_set;

    AST_DONE_NEEDS_ARRIVALS: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && !cal_req && $rose(cal_done) == 1'b0 && &seen_vec) |=> (cal_done || cal_req)); // R5
endmodule

// File: tb/rd_level_aligner_bench.sv
`timescale 1ns/1ps
module rd_level_aligner_bench;
    localparam int NL = 4;
    localparam int W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cal_req = 1'b0;
    logic [NL*W-1:0]   lane_din = '0;
    logic [NL*W-1:0]   aligned_dout;
    logic [NL*2-1:0]   lane_dly;
    logic              cal_busy;
    logic              cal_done;
    logic              cal_err;

    rd_level_aligner #(.NUM_LANES(NL), .LANE_W(W), .CAL_TIMEOUT(64)) u_rd_level_aligner (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_req      (cal_req),
        .lane_din     (lane_din),
        .aligned_dout (aligned_dout),
        .lane_dly     (lane_dly),
        .cal_busy     (cal_busy),
        .cal_done     (cal_done),
        .cal_err      (cal_err)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cur = 0;
    int mode = 0;          // 0 zeros, 1 training, 2 data
    int ts = 0;
    int stuck = -1;
    int settle = 0;
    bit cmp_on = 0;
    bit r6_on = 0;
    bit req_v = 0;
    bit rst_v = 0;
    int skew [NL];
    int exp_d [NL];
    int amax = 0;
    logic [7:0] hist [NL][1024];

    function automatic logic [7:0] gen(int lane, int n);
        return 8'((n * 29 + lane * 71 + 5) & 255);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at step %0d: actual %0h expected %0h", req, cur, act, exp);
        end
    endtask

    // One half-cycle step: compare on the falling edge, then drive next inputs.
    task automatic step();
        @(negedge clk);
        cur++;
        if (cmp_on && cur >= settle) begin
            for (int i = 0; i < NL; i++) begin
                chk("R2", 32'(aligned_dout[i*W +: W]), 32'(hist[i][(cur - 1 - exp_d[i]) & 1023]));
                if (r6_on)
                    chk("R6", 32'(aligned_dout[i*W +: W]), 32'(gen(i, (cur - 1 - amax) / 2)));
            end
        end
        for (int i = 0; i < NL; i++) begin
            int rel;
            logic [7:0] v;
            rel = cur + 1 - skew[i];
            case (mode)
                1: v = (rel >= ts && stuck != i) ? 8'hFF : 8'h00;
                2: v = gen(i, rel / 2);
                default: v = 8'h00;
            endcase
            lane_din[i*W +: W] = v;
            hist[i][(cur + 1) & 1023] = v;
        end
        cal_req = req_v;
        rst_n = rst_v;
    endtask

    task automatic set_skew(int s0, int s1, int s2, int s3);
        skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
    endtask

    task automatic run_cal(bit restart);
        int amin;
        bit exp_err;
        logic [NL*2-1:0] exp_enc;
        cmp_on = 0; r6_on = 0; mode = 0;
        repeat (6) step();
        req_v = 1; step(); req_v = 0; step();
        chk("R3 busy", 32'(cal_busy), 32'd1);
        chk("R3 done", 32'(cal_done), 32'd0);
        chk("R3 err", 32'(cal_err), 32'd0);
        chk("R3 dly", 32'(lane_dly), 32'd0);
        if (restart) begin
            ts = cur + 1; mode = 1;       // partial burst that must be discarded
            repeat (3) step();
            mode = 0;
            step();
            req_v = 1; step(); req_v = 0; step();
            chk("R10 busy", 32'(cal_busy), 32'd1);
            chk("R10 done", 32'(cal_done), 32'd0);
            repeat (2) step();
        end
        ts = cur + 6; mode = 1;
        for (int n = 0; n < 120 && !cal_done; n++) step();
        amax = skew[0]; amin = skew[0];
        for (int i = 1; i < NL; i++) begin
            if (skew[i] > amax) amax = skew[i];
            if (skew[i] < amin) amin = skew[i];
        end
        exp_err = (amax - amin > 3) || (stuck >= 0);
        exp_enc = '0;
        for (int i = 0; i < NL; i++) begin
            exp_d[i] = exp_err ? 0 : amax - skew[i];
            exp_enc[i*2 +: 2] = 2'(exp_d[i]);
        end
        chk(exp_err ? "R7/R8 done" : "R5 done", 32'(cal_done), 32'd1);
        chk(exp_err ? "R7/R8 err" : "R5 err", 32'(cal_err), 32'(exp_err));
        chk("R5 busy", 32'(cal_busy), 32'd0);
        chk(exp_err ? "R7/R8 dly" : "R5 dly", 32'(lane_dly), 32'(exp_enc));
        stuck = -1;
        mode = 2; cmp_on = 1; r6_on = !exp_err; settle = cur + 10;
    endtask

    initial begin
        set_skew(0, 0, 0, 0);
        for (int i = 0; i < NL; i++) exp_d[i] = 0;
        rst_v = 0;
        repeat (4) step();
        chk("R1 dout", aligned_dout, 32'd0);
        chk("R1 dly", 32'(lane_dly), 32'd0);
        chk("R1 flags", {29'd0, cal_busy, cal_done, cal_err}, 32'd0);
        rst_v = 1;
        step(); step();
        chk("R1 flags after release", {29'd0, cal_busy, cal_done, cal_err}, 32'd0);

        // Uncalibrated pass-through with zero settings.
        mode = 2; cmp_on = 1; settle = cur + 8;
        repeat (40) step();

        // Staggered lanes: needs every delay value.
        set_skew(0, 1, 2, 3);
        run_cal(0);
        repeat (60) step();

        // R9: a new burst without a request leaves settings alone.
        begin
            logic [NL*2-1:0] held;
            held = lane_dly;
            r6_on = 0; mode = 0;
            repeat (4) step();
            ts = cur + 3; mode = 1;
            repeat (14) step();
            chk("R9 dly", 32'(lane_dly), 32'(held));
            chk("R9 done", 32'(cal_done), 32'd1);
            chk("R9 busy", 32'(cal_busy), 32'd0);
            mode = 2; r6_on = 1; settle = cur + 10;
            repeat (30) step();
        end

        // Reversed order with a restart mid-training.
        set_skew(3, 0, 2, 1);
        run_cal(1);
        repeat (60) step();

        // All lanes equally late.
        set_skew(2, 2, 2, 2);
        run_cal(0);
        repeat (40) step();

        // Spread of four half steps: too wide.
        set_skew(0, 4, 1, 2);
        run_cal(0);
        repeat (40) step();

        // A lane that never toggles: timeout.
        set_skew(1, 0, 0, 1);
        stuck = 2;
        run_cal(0);
        repeat (40) step();

        // Recovery after an error.
        set_skew(1, 0, 0, 1);
        run_cal(0);
        repeat (60) step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule